// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block is the software-visible register side of an I/O interrupt redirection controller. A bus master reaches it through two offsets only: an 8-bit select register picks one internal 32-bit word, and a data window reads or writes the word that is currently selected. The words behind the window are an identifier register, a read-only version word, and a table of 64-bit redirection entries. Each entry is reached as a low and a high 32-bit half.

An entry uses this bit layout: vector in [7:0], delivery mode in [10:8], destination mode in [11], remote-request status in [14], trigger mode in [15] (1 means level), mask in [16], and destination in [63:56]. The remote-request bit is set by the delivery logic through a side input. A low-half write clears it again. After each entry write the block reports two events. It raises a one-cycle service request when a level-triggered entry has its pin pending. It raises a one-cycle notice when the write flipped the entry's mask bit.

Top module: `irq_redir_regfile`

## Requirements
- R1: The select register sits at offset 0x00 and the data window at offset 0x10. A write to the select register stores wdata[7:0], and reading it returns that byte zero-extended. Any other offset reads as 0, and writes to it change nothing.
- R2: A read returns its data on bus_rdata in the cycle after bus_rd is high. bus_rdata is 0 in every cycle that does not follow a read.
- R3: Select 0x01 reads the version word: NPINS-1 in bits 23:16, VERSION in bits 7:0, and zeros elsewhere. Window writes with this select change nothing.
- R4: A window write with select 0x00 loads the 4-bit identifier from wdata[27:24]. Reads with select 0x00 or 0x02 both return the identifier in bits 27:24 and zeros elsewhere. Window writes with select 0x02 change nothing.
- R5: For a select of 0x10 or above, the entry index is (select-0x10)>>1. Select bit 0 = 1 reaches bits 63:32 and select bit 0 = 0 reaches bits 31:0.
- R6: Selects 0x03 to 0x0F, and selects whose index is NPINS or more, read as all ones. Window writes with such selects change no state.
- R7: A low-half write stores wdata with bit 14 forced to 0, which clears the remote-request bit. A high-half write leaves bits 31:0 unchanged, the remote-request bit included.
- R8: A rirr_set pulse sets bit 14 of entry rirr_idx. An index of NPINS or more is ignored. If a low-half write hits the same entry in the same cycle, the write wins and the bit ends at 0.
- R9: While rst is high, every entry is reset to 0x0000_0000_0001_0000, which is masked with all other bits zero. The select register, the identifier and the sampled pin state are also cleared.
- R10: pin_level is sampled every cycle. A write that lands on an in-range entry whose new bit 15 is 1, while that pin's sample from the previous cycle is 1, gives a one-cycle svc_valid in the next cycle. svc_index carries the entry index and svc_entry carries the entry value as written.
- R11: A write that changes an entry's bit 16 gives a one-cycle mask_chg_valid in the next cycle. mask_chg_index carries the entry index and mask_chg_mask carries the new mask value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_level | input | NPINS | Pin request levels |
| rirr_set | input | 1 | Delivery logic marks an entry as awaiting end of interrupt |
| rirr_idx | input | IDX_W | Entry index for rirr_set |
| svc_valid | output | 1 | Delivery attempt request |
| svc_index | output | IDX_W | Entry index of the request |
| svc_entry | output | 64 | Entry contents of the request |
| mask_chg_valid | output | 1 | Mask bit changed |
| mask_chg_index | output | IDX_W | Entry whose mask changed |
| mask_chg_mask | output | 1 | New mask value |

## Verification
Two functions can fall in the same cycle on one entry. The delivery side can set the remote-request bit while software writes that same entry. The bench provokes this directly: it pulses rirr_set in the same cycle as a low-half write to the same index, and again alongside a high-half write. It also keeps the collision going through a long random phase in which both sources draw from a small index range. A behavioural model applies the write first and then the set, unless the write was a low half to that entry. Every registered output is compared with this model on every cycle, and the bit is read back through the window afterwards.

// File: rtl/irr_pkg.sv
package irr_pkg;
  localparam int ENTRY_W  = 64;
  localparam int RIRR_BIT = 14;
  localparam int TRIG_BIT = 15;
  localparam int MASK_BIT = 16;
  localparam logic [ENTRY_W-1:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  localparam logic [7:0] SEL_ID    = 8'h00;
  localparam logic [7:0] SEL_VER   = 8'h01;
  localparam logic [7:0] SEL_ARB   = 8'h02;
  localparam logic [7:0] SEL_TBASE = 8'h10;

  typedef enum logic [2:0] {
    K_ID,
    K_VER,
    K_ARB,
    K_ENT,
    K_BAD
  } sel_kind_e;
endpackage

// File: rtl/irr_sel_decode.sv
module irr_sel_decode
  import irr_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int IDX_W = 5
) (
  input  logic [7:0]       sel,
  output sel_kind_e        kind,
  output logic [IDX_W-1:0] idx,
  output logic             hi
);
  logic [7:0] off;
  logic [6:0] raw_idx;

  always_comb begin
    off     = sel - SEL_TBASE;
    raw_idx = off[7:1];
    hi      = sel[0];
    idx     = '0;
    if (sel == SEL_ID) begin
      kind = K_ID;
    end else if (sel == SEL_VER) begin
      kind = K_VER;
    end else if (sel == SEL_ARB) begin
      kind = K_ARB;
    end else if (sel < SEL_TBASE) begin
      kind = K_BAD;
    end else if (int'(raw_idx) < NPINS) begin
      kind = K_ENT;
      idx  = IDX_W'(raw_idx);
    end else begin
      kind = K_BAD;
    end
  end
endmodule

// File: rtl/irr_redir_table.sv
module irr_redir_table
  import irr_pkg::*;
#(
  parameter int NPINS = 24,
  parameter int IDX_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_hi,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [31:0]        wdata,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_entry,
  input  logic               rirr_set,
  input  logic [IDX_W-1:0]   rirr_idx,
  input  logic [NPINS-1:0]   pend,
  output logic               svc_valid,
  output logic [IDX_W-1:0]   svc_index,
  output logic [ENTRY_W-1:0] svc_entry,
  output logic               mask_chg_valid,
  output logic [IDX_W-1:0]   mask_chg_index,
  output logic               mask_chg_mask
);
  logic [ENTRY_W-1:0] ent_q   [NPINS];
  logic [ENTRY_W-1:0] ent_nxt [NPINS];
  logic [ENTRY_W-1:0] cur_ent;
  logic [ENTRY_W-1:0] new_ent;

  assign rd_entry = ent_q[rd_idx];
  assign cur_ent  = ent_q[wr_idx];

  always_comb begin
    if (wr_hi) begin
      new_ent = {wdata, cur_ent[31:0]};
    end else begin
      new_ent = {cur_ent[63:32], wdata};
      new_ent[RIRR_BIT] = 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      ent_nxt[i] = ent_q[i];
      if (wr_en && wr_idx == IDX_W'(i)) ent_nxt[i] = new_ent;
      if (rirr_set && rirr_idx == IDX_W'(i) &&
          !(wr_en && !wr_hi && wr_idx == IDX_W'(i)))
        ent_nxt[i][RIRR_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPINS; i++) ent_q[i] <= ENTRY_RST;
    end else begin
      for (int i = 0; i < NPINS; i++) ent_q[i] <= ent_nxt[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      svc_valid      <= 1'b0;
      svc_index      <= '0;
      svc_entry      <= '0;
      mask_chg_valid <= 1'b0;
      mask_chg_index <= '0;
      mask_chg_mask  <= 1'b0;
    end else begin
      svc_valid      <= 1'b0;
      mask_chg_valid <= 1'b0;
      if (wr_en) begin
        svc_valid      <= new_ent[TRIG_BIT] && pend[wr_idx];
        svc_index      <= wr_idx;
        svc_entry      <= new_ent;
        mask_chg_valid <= new_ent[MASK_BIT] != cur_ent[MASK_BIT];
        mask_chg_index <= wr_idx;
        mask_chg_mask  <= new_ent[MASK_BIT];
      end
    end
  end

  // R7: the entry hit by a low-half write holds a clear remote-request bit
  a_r7_low_write_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_hi) |=> (ent_q[$past(wr_idx)][RIRR_BIT] == 1'b0));

  // R11: the reported mask value matches the stored entry
  a_r11_mask_matches: assert property (@(posedge clk) disable iff (rst)
    mask_chg_valid |-> (ent_q[mask_chg_index][MASK_BIT] == mask_chg_mask));

  // R10: service requests only ever name level-triggered, in-range entries
  a_r10_svc_level: assert property (@(posedge clk) disable iff (rst)
    svc_valid |-> (svc_entry[TRIG_BIT] && (int'(svc_index) < NPINS)));
endmodule

// File: rtl/irq_redir_regfile.sv
module irq_redir_regfile
  import irr_pkg::*;
#(
  parameter int              NPINS   = 24,
  parameter logic [7:0]      VERSION = 8'h11,
  parameter int              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] SEL_OFF = ADDR_W'('h00),
  parameter logic [ADDR_W-1:0] WIN_OFF = ADDR_W'('h10),
  localparam int             IDX_W   = (NPINS > 1) ? $clog2(NPINS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NPINS-1:0]   pin_level,
  input  logic               rirr_set,
  input  logic [IDX_W-1:0]   rirr_idx,
  output logic               svc_valid,
  output logic [IDX_W-1:0]   svc_index,
  output logic [63:0]        svc_entry,
  output logic               mask_chg_valid,
  output logic [IDX_W-1:0]   mask_chg_index,
  output logic               mask_chg_mask
);
  localparam logic [7:0]  MAXPIN   = 8'(NPINS - 1);
  localparam logic [31:0] VER_WORD = {8'h00, MAXPIN, 8'h00, VERSION};

  logic [7:0]       sel_q;
  logic [3:0]       id_q;
  logic [NPINS-1:0] pend_q;
  sel_kind_e        kind;
  logic [IDX_W-1:0] dec_idx;
  logic             dec_hi;
  logic [63:0]      rd_entry;
  logic             win_wr;
  logic             tbl_wr;
  logic [31:0]      rd_word;

  irr_sel_decode #(.NPINS(NPINS), .IDX_W(IDX_W)) u_dec (
    .sel  (sel_q),
    .kind (kind),
    .idx  (dec_idx),
    .hi   (dec_hi)
  );

  assign win_wr = bus_wr && (bus_addr == WIN_OFF);
  assign tbl_wr = win_wr && (kind == K_ENT);

  irr_redir_table #(.NPINS(NPINS), .IDX_W(IDX_W)) u_tbl (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (tbl_wr),
    .wr_hi          (dec_hi),
    .wr_idx         (dec_idx),
    .wdata          (bus_wdata),
    .rd_idx         (dec_idx),
    .rd_entry       (rd_entry),
    .rirr_set       (rirr_set),
    .rirr_idx       (rirr_idx),
    .pend           (pend_q),
    .svc_valid      (svc_valid),
    .svc_index      (svc_index),
    .svc_entry      (svc_entry),
    .mask_chg_valid (mask_chg_valid),
    .mask_chg_index (mask_chg_index),
    .mask_chg_mask  (mask_chg_mask)
  );

  always_comb begin
    rd_word = '0;
    if (bus_addr == SEL_OFF) begin
      rd_word = {24'h0, sel_q};
    end else if (bus_addr == WIN_OFF) begin
      case (kind)
        K_ID, K_ARB: rd_word = {4'h0, id_q, 24'h0};
        K_VER:       rd_word = VER_WORD;
        K_ENT:       rd_word = dec_hi ? rd_entry[63:32] : rd_entry[31:0];
        default:     rd_word = '1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q     <= '0;
      id_q      <= '0;
      pend_q    <= '0;
      bus_rdata <= '0;
    end else begin
      pend_q    <= pin_level;
      bus_rdata <= bus_rd ? rd_word : 32'h0;
      if (bus_wr && bus_addr == SEL_OFF) sel_q <= bus_wdata[7:0];
      if (win_wr && kind == K_ID) id_q <= bus_wdata[27:24];
    end
  end

  // R9: select and identifier come out of reset cleared
  a_r9_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sel_q == 8'h00 && id_q == 4'h0));

  // R2: no read in the previous cycle means zero read data
  a_r2_rdata_idle: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> (bus_rdata == 32'h0));

  // R3: a window read with the version select returns the fixed word
  a_r3_version_word: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_rd) && $past(bus_addr) == WIN_OFF && $past(sel_q) == SEL_VER)
      |-> (bus_rdata == VER_WORD));
endmodule

// File: tb/irq_redir_regfile_tb.sv
`timescale 1ns/100ps
module irq_redir_regfile_tb;
  localparam int NP = 24;
  localparam int IW = 5;
  localparam logic [7:0] VER = 8'h11;
  localparam logic [7:0] SELA = 8'h00;
  localparam logic [7:0] WINA = 8'h10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pin_level = 0;
  logic rirr_set = 0;
  logic [IW-1:0] rirr_idx = 0;
  logic svc_valid, mask_chg_valid, mask_chg_mask;
  logic [IW-1:0] svc_index, mask_chg_index;
  logic [63:0] svc_entry;

  int nchk = 0, nfail = 0;
  string cur_req = "R9";
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_redir_regfile u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_level(pin_level),
    .rirr_set(rirr_set), .rirr_idx(rirr_idx), .svc_valid(svc_valid),
    .svc_index(svc_index), .svc_entry(svc_entry), .mask_chg_valid(mask_chg_valid),
    .mask_chg_index(mask_chg_index), .mask_chg_mask(mask_chg_mask)
  );

  // Behavioural reference model
  logic [63:0] m_ent [NP];
  logic [7:0]  m_sel;
  logic [3:0]  m_id;
  logic [NP-1:0] m_pend;
  logic [31:0] e_rdata;
  logic e_svc, e_mc, e_mcm;
  int   e_svc_idx, e_mc_idx;
  logic [63:0] e_svc_ent;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int ix;
    if (a == SELA) return {24'h0, m_sel};
    if (a != WINA) return 32'h0;
    if (m_sel == 8'h00 || m_sel == 8'h02) return {4'h0, m_id, 24'h0};
    if (m_sel == 8'h01) return {8'h00, 8'(NP - 1), 8'h00, VER};
    if (m_sel < 8'h10) return 32'hFFFF_FFFF;
    ix = (int'(m_sel) - 16) >> 1;
    if (ix >= NP) return 32'hFFFF_FFFF;
    return m_sel[0] ? m_ent[ix][63:32] : m_ent[ix][31:0];
  endfunction

  always @(posedge clk) begin
    int ix;
    int lo_hit;
    logic [63:0] old;
    if (rst) begin
      for (int i = 0; i < NP; i++) m_ent[i] = 64'h0000_0000_0001_0000;
      m_sel = 0; m_id = 0; m_pend = 0;
      e_rdata = 0; e_svc = 0; e_mc = 0; e_mcm = 0;
      e_svc_idx = 0; e_mc_idx = 0; e_svc_ent = 0;
    end else begin
      lo_hit = -1;
      e_rdata = bus_rd ? m_read(bus_addr) : 32'h0;
      e_svc = 0; e_mc = 0;
      if (bus_wr && bus_addr == WINA) begin
        if (m_sel == 8'h00) m_id = bus_wdata[27:24];
        else if (m_sel >= 8'h10 && ((int'(m_sel) - 16) >> 1) < NP) begin
          ix  = (int'(m_sel) - 16) >> 1;
          old = m_ent[ix];
          if (m_sel[0]) m_ent[ix][63:32] = bus_wdata;
          else begin
            m_ent[ix][31:0] = bus_wdata;
            m_ent[ix][14] = 1'b0;
            lo_hit = ix;
          end
          e_svc = m_ent[ix][15] && m_pend[ix];
          e_svc_idx = ix; e_svc_ent = m_ent[ix];
          e_mc = old[16] != m_ent[ix][16];
          e_mc_idx = ix; e_mcm = m_ent[ix][16];
        end
      end
      if (bus_wr && bus_addr == SELA) m_sel = bus_wdata[7:0];
      if (rirr_set && int'(rirr_idx) < NP && int'(rirr_idx) != lo_hit)
        m_ent[rirr_idx][14] = 1'b1;
      m_pend = pin_level;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model (R2 read timing, R10, R11)
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk({cur_req, " R2 rdata"}, 64'(bus_rdata), 64'(e_rdata));
      chk({cur_req, " R10 svc_valid"}, 64'(svc_valid), 64'(e_svc));
      if (e_svc) begin
        chk({cur_req, " R10 svc_index"}, 64'(svc_index), 64'(e_svc_idx));
        chk({cur_req, " R10 svc_entry"}, svc_entry, e_svc_ent);
      end
      chk({cur_req, " R11 mask_chg_valid"}, 64'(mask_chg_valid), 64'(e_mc));
      if (e_mc) begin
        chk({cur_req, " R11 mask_chg_index"}, 64'(mask_chg_index), 64'(e_mc_idx));
        chk({cur_req, " R11 mask_chg_mask"}, 64'(mask_chg_mask), 64'(e_mcm));
      end
    end
  end

  task automatic op(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; rirr_set = 0;
  endtask

  task automatic wsel(input logic [7:0] s);
    op(1, 0, SELA, {24'h0, s});
  endtask

  task automatic wwin(input logic [31:0] d);
    op(1, 0, WINA, d);
  endtask

  task automatic rexp(input string req, input logic [7:0] a, input logic [31:0] exp);
    op(0, 1, a, 0);
    chk(req, 64'(bus_rdata), 64'(exp));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    cur_req = "R9";
    rexp("R9 select reset", SELA, 32'h0);
    rexp("R9 id reset", WINA, 32'h0);
    for (int i = 0; i < NP; i++) begin
      wsel(8'(16 + 2 * i));
      rexp("R9 entry low reset", WINA, 32'h0001_0000);
    end

    cur_req = "R1";
    wsel(8'h25);
    rexp("R1 select readback", SELA, 32'h25);
    rexp("R1 other offset", 8'h04, 32'h0);
    op(1, 0, 8'h04, 32'hFFFF_FFFF);
    rexp("R1 other write ignored", SELA, 32'h25);

    cur_req = "R3";
    wsel(8'h01);
    rexp("R3 version", WINA, 32'h0017_0011);
    wwin(32'h1234_5678);
    rexp("R3 version unchanged", WINA, 32'h0017_0011);

    cur_req = "R4";
    wsel(8'h00);
    wwin(32'hA500_0000);
    rexp("R4 id read", WINA, 32'h0500_0000);
    wsel(8'h02);
    rexp("R4 arb read", WINA, 32'h0500_0000);
    wwin(32'h0F00_0000);
    rexp("R4 arb write ignored", WINA, 32'h0500_0000);

    cur_req = "R5";
    wsel(8'h17); wwin(32'hDEAD_BEEF);
    wsel(8'h16); wwin(32'h0000_00A3);
    wsel(8'h17); rexp("R5 entry3 high", WINA, 32'hDEAD_BEEF);
    wsel(8'h16); rexp("R5 entry3 low", WINA, 32'h0000_00A3);
    wsel(8'h3F); wwin(32'h5500_0000);
    rexp("R5 last entry high", WINA, 32'h5500_0000);

    cur_req = "R6";
    wsel(8'h07); rexp("R6 reserved select", WINA, 32'hFFFF_FFFF);
    wwin(32'h0);
    wsel(8'h40); rexp("R6 beyond table", WINA, 32'hFFFF_FFFF);
    wwin(32'h0);
    wsel(8'h3F); rexp("R6 neighbour intact", WINA, 32'h5500_0000);

    cur_req = "R7";
    rirr_idx = 5'd3; rirr_set = 1; op(0, 0, 8'h00, 0);
    wsel(8'h16); rexp("R7 rirr set visible", WINA, 32'h0000_40A3);
    wsel(8'h17); wwin(32'h1111_2222);
    wsel(8'h16); rexp("R7 high write keeps low", WINA, 32'h0000_40A3);
    wwin(32'h0000_40B4);
    rexp("R7 low write clears rirr", WINA, 32'h0000_00B4);

    cur_req = "R8";
    rirr_idx = 5'd3; rirr_set = 1; wwin(32'h0000_00C5);
    rexp("R8 low write beats set", WINA, 32'h0000_00C5);
    wsel(8'h17);
    rirr_idx = 5'd3; rirr_set = 1; wwin(32'h3333_4444);
    wsel(8'h16); rexp("R8 high write with set", WINA, 32'h0000_40C5);
    rirr_idx = 5'd30; rirr_set = 1; op(0, 0, 8'h00, 0);

    cur_req = "R10";
    pin_level = 24'h000010;
    wsel(8'h18); wwin(32'h0000_8021);
    chk("R10 level pending svc", 64'(svc_valid), 64'd1);
    wwin(32'h0000_0021);
    chk("R10 edge no svc", 64'(svc_valid), 64'd0);
    pin_level = 0; @(negedge clk);
    wwin(32'h0000_8021);
    chk("R10 not pending no svc", 64'(svc_valid), 64'd0);

    cur_req = "R11";
    wsel(8'h1A); wwin(32'h0001_0030);
    chk("R11 no toggle", 64'(mask_chg_valid), 64'd0);
    wwin(32'h0000_0030);
    chk("R11 unmask pulse", 64'(mask_chg_valid), 64'd1);
    wwin(32'h0001_0030);
    chk("R11 mask pulse value", 64'(mask_chg_mask), 64'd1);

    cur_req = "mix R8 R10";
    for (int n = 0; n < 3000; n++) begin
      int k;
      k = int'($urandom_range(0, 9));
      pin_level = NP'($urandom);
      rirr_set  = ($urandom_range(0, 3) == 0);
      rirr_idx  = IW'($urandom_range(0, 4));
      case (k)
        0, 1: op(1, 0, SELA, {24'h0, 8'($urandom_range(0, 4) == 0 ?
                   $urandom_range(0, 3) : $urandom_range(16, 25))});
        2, 3, 4: op(1, 0, WINA, $urandom);
        5, 6: op(0, 1, WINA, 0);
        7: op(0, 1, SELA, 0);
        8: op(($urandom_range(0, 1) == 1), ($urandom_range(0, 1) == 1), 8'(4 * $urandom_range(0, 63)), $urandom);
        default: op(0, 0, 0, 0);
      endcase
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #400000;
    nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule